// File: doc/BRIEF.md
# Charge-Balance Ratio Measurement Sequencer

This block is the digital controller for a charge-balance converter that measures the ratio of two currents. An external integrator and comparator produce a single comparator level, `cmp_i`. The block drives `sw_close_o`, which selects the phase in which the combined current charges the integrator. One cascaded BCD counter does two jobs in each measurement cycle. It first times a fixed switch-closed phase of exactly 10^NDEC counted clocks, and opens the switch when that phase ends. It then keeps counting through the discharge phase.

A falling edge on the synchronized comparator level ends one cycle and starts the next. A short state machine then runs three steps, one clock each and in a fixed order. It captures the running count into the display register, closes the switch, and clears the counter. The captured total N is the length of the fixed phase plus the length of the discharge phase, so the current ratio is N / 10^NDEC. N is shown as NDEC+1 BCD digits, with an overflow flag for totals too large to show.

Top module: `cb_ratio_seq`

## Requirements
- R1: While `rst_ni` is low, `sw_close_o`, `disp_bcd_o` and `disp_ovf_o` are all zero. After reset no counting takes place until the first falling edge of the synchronized comparator. That first edge therefore captures a total of zero.
- R2: Each 1-to-0 transition of `cmp_i`, seen after a two-flop synchronizer, starts exactly one capture/close/clear sequence. The display then shows the total of the cycle that just ended.
- R3: The steps run in order, one clock each. The display register is updated 4 clock edges after the falling `cmp_i` is driven. `sw_close_o` goes high one edge later. The counter is cleared on the edge after that.
- R4: `sw_close_o` goes low on the counted clock that carries out of decade NDEC-1, which is exactly 10^NDEC counted clocks after the clear (1000 with the default NDEC=3).
- R5: The counter advances only when the sequencer is in its run state and the synchronized comparator is high. While the comparator is low, counting is inhibited, so a longer low period does not change the captured total.
- R6: The captured total N equals the number of clock edges at which `cmp_i` was high during the run state. N is shown in BCD, with decimal digit i in bits [4i+3:4i] of `disp_bcd_o`.
- R7: If N exceeds 10^(NDEC+1)-1, `disp_ovf_o` is 1 and the digits show N modulo 10^(NDEC+1). The flag is cleared with the counter, so each cycle reports its own overflow.
- R8: Clearing the counter and the counting that follows leave `disp_bcd_o` and `disp_ovf_o` unchanged until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_i | input | 1 | Asynchronous comparator level, high below threshold |
| sw_close_o | output | 1 | High while the combined-current switch is closed |
| disp_bcd_o | output | 4*(NDEC+1) | Captured total N as BCD digits, least significant digit lowest |
| disp_ovf_o | output | 1 | Captured total exceeded the display range |

## Verification
The bench uses a two-decade configuration and sweeps every comparator-high length from 1 to 130 clocks. This shows that the captured total tracks the high time exactly across every digit rollover, both below and above the fixed phase. It repeats one length with a much longer low period, which separates true inhibition from a counter that runs during the low phase. Lengths at and beyond the display range separate wrap-plus-flag behaviour from saturation, and a short cycle afterwards confirms the flag clears. A single long cycle probed clock by clock pins down the switch-open instant and the order of capture and switch close. A reset in mid-count confirms that nothing before the first edge is counted.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_LATCH,
    ST_SET,
    ST_CLR
  } seq_state_e;
endpackage

// File: rtl/cbr_sync.sv
module cbr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/cbr_decade.sv
module cbr_decade (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       inc_i,
  output logic [3:0] q_o,
  output logic       carry_o
);
  logic [3:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 4'd0;
    else if (clr_i)  q_q <= 4'd0;
    else if (inc_i)  q_q <= (q_q == 4'd9) ? 4'd0 : q_q + 4'd1;
  end

  assign q_o     = q_q;
  assign carry_o = inc_i & (q_q == 4'd9);
endmodule

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cbr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic level_i,
  input  logic fixed_done_i,
  output logic count_en_o,
  output logic latch_o,
  output logic clear_o,
  output logic sw_o
);
  seq_state_e state_q, state_d;
  logic       sw_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_RUN: if (fall_i) state_d = ST_LATCH;
      ST_LATCH:        state_d = ST_SET;
      ST_SET:          state_d = ST_CLR;
      ST_CLR:          state_d = ST_RUN;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // switch flag: set by sequence step, cleared by end of fixed phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sw_q <= 1'b0;
    else if (state_q == ST_SET) sw_q <= 1'b1;
    else if (fixed_done_i)      sw_q <= 1'b0;
  end

  assign count_en_o = (state_q == ST_RUN) & level_i;
  assign latch_o    = (state_q == ST_LATCH);
  assign clear_o    = (state_q == ST_CLR);
  assign sw_o       = sw_q;
endmodule

// File: rtl/cb_ratio_seq.sv
module cb_ratio_seq #(
  parameter int NDEC        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmp_i,
  output logic                  sw_close_o,
  output logic [4*(NDEC+1)-1:0] disp_bcd_o,
  output logic                  disp_ovf_o
);
  localparam int NDIG = NDEC + 1;
  localparam int DW   = 4 * NDIG;

  logic          cmp_lvl, cmp_fall;
  logic          count_en, latch_en, clear_en, fixed_done;
  logic [NDIG:0] inc;
  logic [NDIG-1:0] carry;
  logic [DW-1:0] cnt_bcd;
  logic          ovf_q;
  logic [DW-1:0] disp_q;
  logic          disp_ovf_q;

  cbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (cmp_i),
    .level_o (cmp_lvl),
    .fall_o  (cmp_fall)
  );

  cbr_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fall_i       (cmp_fall),
    .level_i      (cmp_lvl),
    .fixed_done_i (fixed_done),
    .count_en_o   (count_en),
    .latch_o      (latch_en),
    .clear_o      (clear_en),
    .sw_o         (sw_close_o)
  );

  assign inc[0] = count_en;

  for (genvar i = 0; i < NDIG; i++) begin : g_dec
    cbr_decade u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clear_en),
      .inc_i   (inc[i]),
      .q_o     (cnt_bcd[4*i +: 4]),
      .carry_o (carry[i])
    );
    assign inc[i+1] = carry[i];
  end

  assign fixed_done = carry[NDEC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ovf_q <= 1'b0;
    else if (clear_en)     ovf_q <= 1'b0;
    else if (inc[NDIG])    ovf_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q     <= '0;
      disp_ovf_q <= 1'b0;
    end else if (latch_en) begin
      disp_q     <= cnt_bcd;
      disp_ovf_q <= ovf_q;
    end
  end

  assign disp_bcd_o = disp_q;
  assign disp_ovf_o = disp_ovf_q;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sw_close_o,
  input logic [DW-1:0] disp_bcd_o,
  input logic          disp_ovf_o,
  input logic [DW-1:0] cnt_bcd,
  input logic          count_en,
  input logic          latch_en,
  input logic          clear_en,
  input logic          fixed_done
);
  p_sw_after_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_close_o) |-> clear_en && $past(latch_en, 2));

  p_clear_after_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_en |-> ##2 clear_en);

  p_sw_open_on_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_close_o) |-> $past(fixed_done));

  p_hold_inhibit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en && !clear_en) |=> $stable(cnt_bcd));

  p_disp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_en |=> $stable(disp_bcd_o) && $stable(disp_ovf_o));
endmodule

bind cb_ratio_seq cbr_checker #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sw_close_o (sw_close_o),
  .disp_bcd_o (disp_bcd_o),
  .disp_ovf_o (disp_ovf_o),
  .cnt_bcd    (cnt_bcd),
  .count_en   (count_en),
  .latch_en   (latch_en),
  .clear_en   (clear_en),
  .fixed_done (fixed_done)
);

// File: tb/sim_cb_ratio_seq.sv
module sim_cb_ratio_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NDEC       = 2;
  localparam int FIXED      = 100;
  localparam int RANGE      = 1000;
  localparam int DW         = 4 * (NDEC + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmp = 1'b1;
  logic          sw;
  logic [DW-1:0] disp;
  logic          ovf;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cb_ratio_seq #(.NDEC(NDEC)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cmp_i      (cmp),
    .sw_close_o (sw),
    .disp_bcd_o (disp),
    .disp_ovf_o (ovf)
  );

  function automatic logic [DW-1:0] bcd_of(int v);
    logic [DW-1:0] r = '0;
    int x = v % RANGE;
    for (int i = 0; i < NDEC + 1; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // comparator high across k clock edges, then low across l
  task automatic pulse(int k, int l);
    @(negedge clk); cmp = 1'b1;
    repeat (k) @(negedge clk);
    cmp = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual %0d expected below 150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sw in reset", 32'(sw), 0);
    chk("R1 disp in reset", 32'(disp), 0);
    chk("R1 ovf in reset", 32'(ovf), 0);
    rst_ni = 1'b1;

    // no counting before first edge
    pulse(50, 5);
    chk("R1 first capture zero", 32'(disp), 0);
    chk("R3 sw closed after sequence", 32'(sw), 1);

    // sweep of high lengths
    for (int k = 1; k <= 130; k++) begin
      pulse(k, 5);
      chk($sformatf("R2 R6 k=%0d disp", k), 32'(disp), 32'(bcd_of(k)));
      chk($sformatf("R6 k=%0d ovf", k), 32'(ovf), 0);
    end

    // long low period does not add counts
    pulse(77, 40);
    chk("R5 long low inhibited", 32'(disp), 32'(bcd_of(77)));
    pulse(64, 5);
    chk("R5 after long low", 32'(disp), 32'(bcd_of(64)));

    // switch-open instant
    @(negedge clk); cmp = 1'b1;
    repeat (FIXED + 1) @(negedge clk);
    chk("R4 sw still closed at last fixed clock", 32'(sw), 1);
    @(negedge clk);
    chk("R4 sw open after fixed phase", 32'(sw), 0);
    repeat (120 - FIXED - 2) @(negedge clk);
    cmp = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 disp old before capture", 32'(disp), 32'(bcd_of(64)));
    @(negedge clk);
    chk("R3 disp captured first", 32'(disp), 32'(bcd_of(120)));
    chk("R3 sw not yet closed", 32'(sw), 0);
    @(negedge clk);
    chk("R3 sw closed next", 32'(sw), 1);

    // display holds across clear and counting
    pulse(37, 5);
    chk("R8 capture 37", 32'(disp), 32'(bcd_of(37)));
    @(negedge clk); cmp = 1'b1;
    repeat (60) @(negedge clk);
    chk("R8 disp held while counting", 32'(disp), 32'(bcd_of(37)));
    repeat (20) @(negedge clk);
    cmp = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 next capture", 32'(disp), 32'(bcd_of(80)));

    // overflow
    pulse(999, 5);
    chk("R7 top of range digits", 32'(disp), 32'(bcd_of(999)));
    chk("R7 top of range ovf", 32'(ovf), 0);
    pulse(1000, 5);
    chk("R7 wrap digits", 32'(disp), 32'(bcd_of(1000)));
    chk("R7 wrap ovf", 32'(ovf), 1);
    pulse(1003, 5);
    chk("R7 beyond digits", 32'(disp), 32'(bcd_of(1003)));
    chk("R7 beyond ovf", 32'(ovf), 1);
    pulse(5, 5);
    chk("R7 ovf cleared", 32'(ovf), 0);
    chk("R7 small after ovf", 32'(disp), 32'(bcd_of(5)));

    // reset in mid-count
    @(negedge clk); cmp = 1'b1;
    repeat (30) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 sw cleared by reset", 32'(sw), 0);
    chk("R1 disp cleared by reset", 32'(disp), 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    cmp = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", 32'(disp), 0);
    pulse(9, 5);
    chk("R2 resumes after reset", 32'(disp), 32'(bcd_of(9)));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule